// File: doc/BRIEF.md
# Iterative Integer Divider with Exception-Free Corner Cases

This unit divides one 32-bit operand by another and returns either the quotient or the remainder. Each operation is signed or unsigned. The caller places the operands, an operation code and a signedness code on the inputs and pulses `start_i` for one cycle. The unit then takes the magnitudes of the operands and runs an unsigned shift-and-subtract loop that retires one quotient bit per clock. At the end it corrects the signs and presents the answer on `result_o`, marked by a one-cycle `done_o` pulse.

A zero divisor and the one signed overflow (the most negative value divided by minus one) never raise a trap. Both produce fixed, well-defined answers. The unit recognises these cases when it accepts the start and answers them in a single cycle without running the loop. The answer stays on `result_o` until the next operation completes. A start request that arrives while a loop is running is dropped.

Top module: `int_divider`

## Requirements
- R1: With signedness code 2'b00 the operands are unsigned. Operation code 4'b1101 returns the remainder. Operation code 4'b1100 returns the floor quotient. For example, 4294967295 / 2147483647 = 2, and 4294967295 divided by 2684354564 gives quotient 1 and remainder 1610612731.
- R2: With signedness code 2'b11 the operands are two's complement. The quotient truncates toward zero and the remainder takes the sign of the dividend. For example, 2147483647 / -1 = -2147483647, -2147483648 / 2147483647 = -1, and -1 divided by any negative divisor other than -1 gives quotient 0 and remainder -1.
- R3: A zero divisor gives an all-ones quotient and returns the dividend unchanged as the remainder, in both signed and unsigned mode.
- R4: A signed division of -2147483648 by -1 gives quotient -2147483648 and remainder 0. The same operands in unsigned mode go through the normal loop and give quotient 0 and remainder 2147483648.
- R5: A zero-divisor or signed-overflow request raises `done_o` in the cycle right after the start is taken, and `busy_o` stays low throughout.
- R6: Any other request holds `busy_o` high for exactly 32 cycles. `done_o` is then high in the 33rd cycle after the cycle in which the start is taken.
- R7: `done_o` is high for a single cycle per operation and is never high together with `busy_o`.
- R8: A start pulse while `busy_o` is high is ignored. The running operation finishes on its original schedule with its original operands, and no extra `done_o` follows.
- R9: `result_o` keeps its value from one `done_o` pulse until the next.
- R10: During and after a synchronous active-low reset, `busy_o` and `done_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation; taken only while idle |
| dividend_i | input | 32 | Dividend, sampled with an accepted start |
| divisor_i | input | 32 | Divisor, sampled with an accepted start |
| op_i | input | 4 | 4'b1100 selects quotient, 4'b1101 selects remainder |
| sign_i | input | 2 | 2'b11 selects signed operands, 2'b00 selects unsigned |
| busy_o | output | 1 | High while the shift-subtract loop runs |
| done_o | output | 1 | One-cycle pulse when `result_o` carries a new answer |
| result_o | output | 32 | Quotient or remainder, held until the next completion |

## Verification
The hardest situation to reach from the ports is a start request that arrives in the middle of a running loop. Such a request must leave no trace: the result, the completion time and the count of completions must all stay as they were. The stimulus starts a long unsigned division, waits several cycles, and then pulses start with a zero divisor, an operation that would otherwise finish in one cycle. It then checks that the original quotient appears at the original time and that no second completion follows. The sign fix-up corners are driven through table vectors that pair each sign combination with both result selections. The overflow operands are also run once in unsigned mode, to show that only signed mode takes the single-cycle path.

// File: rtl/int_div_pkg.sv
// Package: shared codes and types for the iterative divider.
// Assumes the caller uses only the listed operation and signedness codes.
package int_div_pkg;
    localparam logic [3:0] OP_QUOTIENT  = 4'b1100;
    localparam logic [3:0] OP_REMAINDER = 4'b1101;
    localparam logic [1:0] SGN_SIGNED   = 2'b11;
    localparam logic [1:0] SGN_UNSIGNED = 2'b00;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
// Operand preparation: forms operand magnitudes, the sign corrections to
// apply afterwards, and flags for the two cases answered without looping.
// Assumes two's complement operands when is_signed_i is high.
module div_operand_prep #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    input  logic            is_signed_i,
    output logic [XLEN-1:0] mag_a_o,
    output logic [XLEN-1:0] mag_b_o,
    output logic            neg_quo_o,
    output logic            neg_rem_o,
    output logic            zero_div_o,
    output logic            overflow_o
);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] MINUS_ONE = '1;

    logic a_neg;
    logic b_neg;

    // Derive magnitudes, sign corrections and special-case flags.
    always_comb begin
        a_neg      = is_signed_i && dividend_i[XLEN-1];
        b_neg      = is_signed_i && divisor_i[XLEN-1];
        mag_a_o    = a_neg ? (~dividend_i + 1'b1) : dividend_i;
        mag_b_o    = b_neg ? (~divisor_i + 1'b1) : divisor_i;
        neg_quo_o  = a_neg ^ b_neg;
        neg_rem_o  = a_neg;
        zero_div_o = (divisor_i == '0);
        overflow_o = is_signed_i && (dividend_i == MOST_NEG) && (divisor_i == MINUS_ONE);
    end
endmodule

// File: rtl/div_shift_sub_core.sv
// Unsigned restoring shift-subtract core: one quotient bit per step.
// Assumes load_i and step_i are never high together; the controller
// counts the steps. The next-state values are exported so that the last
// step's answer can be used in the same cycle it is formed.
module div_shift_sub_core #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [XLEN-1:0] mag_a_i,
    input  logic [XLEN-1:0] mag_b_i,
    output logic [XLEN-1:0] quo_nx_o,
    output logic [XLEN-1:0] rem_nx_o
);
    localparam int WIDE = XLEN + 1;

    logic [XLEN-1:0] quo_q;
    logic [XLEN-1:0] rem_q;
    logic [XLEN-1:0] dvs_q;
    logic [WIDE-1:0] shifted;
    logic [WIDE-1:0] trial;
    logic            fits;

    // One trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted  = {rem_q, quo_q[XLEN-1]};
        fits     = (shifted >= {1'b0, dvs_q});
        trial    = shifted - {1'b0, dvs_q};
        rem_nx_o = fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
        quo_nx_o = {quo_q[XLEN-2:0], fits};
    end

    // Hold the partial remainder, the dividend/quotient shift register and the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            quo_q <= mag_a_i;
            rem_q <= '0;
            dvs_q <= mag_b_i;
        end else if (step_i) begin
            quo_q <= quo_nx_o;
            rem_q <= rem_nx_o;
        end
    end
endmodule

// File: rtl/div_sign_fixup.sv
// Sign fix-up and result selection applied to the unsigned core answer.
// Assumes the negate flags were captured when the operation started.
module div_sign_fixup #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] rem_i,
    input  logic            neg_quo_i,
    input  logic            neg_rem_i,
    input  logic            want_rem_i,
    output logic [XLEN-1:0] result_o
);
    logic [XLEN-1:0] quo_fix;
    logic [XLEN-1:0] rem_fix;

    // Negate where the operand signs call for it, then pick the requested value.
    always_comb begin
        quo_fix  = neg_quo_i ? (~quo_i + 1'b1) : quo_i;
        rem_fix  = neg_rem_i ? (~rem_i + 1'b1) : rem_i;
        result_o = want_rem_i ? rem_fix : quo_fix;
    end
endmodule

// File: rtl/int_divider.sv
// Iterative integer divider, top level. It accepts a start while idle and
// answers zero-divisor and signed-overflow requests in one cycle. All
// other requests run XLEN shift-subtract steps. The result is registered
// and held until the next completion. Assumes start_i is a pulse sampled
// on the rising clock edge.
module int_divider
    import int_div_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] dividend_i,
    input  logic [XLEN-1:0] divisor_i,
    input  logic [3:0]      op_i,
    input  logic [1:0]      sign_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);
    localparam int CNT_W = $clog2(XLEN);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(XLEN - 1);

    div_state_e      state_q;
    logic [CNT_W-1:0] step_q;
    logic            neg_quo_q;
    logic            neg_rem_q;
    logic            want_rem_q;
    logic            done_q;
    logic [XLEN-1:0] result_q;

    logic            accept;
    logic            is_signed;
    logic            want_rem;
    logic            last_step;
    logic [XLEN-1:0] mag_a;
    logic [XLEN-1:0] mag_b;
    logic            neg_quo;
    logic            neg_rem;
    logic            zero_div;
    logic            overflow;
    logic            special;
    logic [XLEN-1:0] special_res;
    logic [XLEN-1:0] quo_nx;
    logic [XLEN-1:0] rem_nx;
    logic [XLEN-1:0] loop_res;

    // Decode the request and spot the start that is taken this cycle.
    always_comb begin
        accept    = start_i && (state_q == ST_IDLE);
        is_signed = (sign_i == SGN_SIGNED);
        want_rem  = (op_i == OP_REMAINDER);
        last_step = (state_q == ST_RUN) && (step_q == LAST_STEP);
        special   = zero_div || overflow;
    end

    div_operand_prep #(.XLEN(XLEN)) prep_i (
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .is_signed_i (is_signed),
        .mag_a_o     (mag_a),
        .mag_b_o     (mag_b),
        .neg_quo_o   (neg_quo),
        .neg_rem_o   (neg_rem),
        .zero_div_o  (zero_div),
        .overflow_o  (overflow)
    );

    // Fixed answers: a zero divisor yields all ones or the dividend; overflow yields the dividend or zero.
    always_comb begin
        if (zero_div) begin
            special_res = want_rem ? dividend_i : '1;
        end else begin
            special_res = want_rem ? '0 : dividend_i;
        end
    end

    div_shift_sub_core #(.XLEN(XLEN)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept && !special),
        .step_i   (state_q == ST_RUN),
        .mag_a_i  (mag_a),
        .mag_b_i  (mag_b),
        .quo_nx_o (quo_nx),
        .rem_nx_o (rem_nx)
    );

    div_sign_fixup #(.XLEN(XLEN)) fixup_i (
        .quo_i      (quo_nx),
        .rem_i      (rem_nx),
        .neg_quo_i  (neg_quo_q),
        .neg_rem_i  (neg_rem_q),
        .want_rem_i (want_rem_q),
        .result_o   (loop_res)
    );

    // Sequence the operation: idle, run XLEN steps, then deliver the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_q     <= '0;
            neg_quo_q  <= 1'b0;
            neg_rem_q  <= 1'b0;
            want_rem_q <= 1'b0;
            done_q     <= 1'b0;
            result_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (special) begin
                    result_q <= special_res;
                    done_q   <= 1'b1;
                end else begin
                    state_q    <= ST_RUN;
                    step_q     <= '0;
                    neg_quo_q  <= neg_quo;
                    neg_rem_q  <= neg_rem;
                    want_rem_q <= want_rem;
                end
            end else if (last_step) begin
                state_q  <= ST_IDLE;
                result_q <= loop_res;
                done_q   <= 1'b1;
            end else if (state_q == ST_RUN) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // Drive the outputs from registered state.
    always_comb begin
        busy_o   = (state_q == ST_RUN);
        done_o   = done_q;
        result_o = result_q;
    end
endmodule

// File: rtl/int_divider_chk.sv
// Protocol checker for the iterative divider, attached by bind.
// Assumes it sees only the top-level ports.
module int_divider_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [XLEN-1:0] divisor_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] result_o
);
    localparam int CW = $clog2(XLEN) + 2;

    logic [CW-1:0] busy_run;

    // Count busy cycles since the last completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (done_o) begin
            busy_run <= '0;
        end else if (busy_o) begin
            busy_run <= busy_run + 1'b1;
        end
    end

    assert_zero_div_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && divisor_i == '0) |=> (done_o && !busy_o));

    assert_loop_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && busy_run != '0) |-> (busy_run == CW'(XLEN)));

    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= CW'(XLEN));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && busy_run < CW'(XLEN - 1)) |=> busy_o);

    assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

bind int_divider int_divider_chk #(.XLEN(XLEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .divisor_i (divisor_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o)
);

// File: tb/int_divider_tb_top.sv
`timescale 1ns/1ps
module int_divider_tb_top;
    localparam int XLEN = 32;
    localparam int NVEC = 24;
    localparam logic [3:0] Q = 4'b1100;
    localparam logic [3:0] R = 4'b1101;
    localparam logic [1:0] S = 2'b11;
    localparam logic [1:0] U = 2'b00;

    // Vector layout: {dividend, divisor, op, sign, expected}
    localparam logic [101:0] VEC [NVEC] = '{
        {32'hFFFFFFFF, 32'h7FFFFFFF, Q, U, 32'h00000002},  // R1
        {32'hFFFFFFFF, 32'hA0000004, Q, U, 32'h00000001},  // R1
        {32'hFFFFFFFF, 32'hA0000004, R, U, 32'h5FFFFFFB},  // R1
        {32'd100,      32'd7,        Q, U, 32'd14},        // R1
        {32'd100,      32'd7,        R, U, 32'd2},         // R1
        {32'hFFFFFFF9, 32'd2,        Q, U, 32'h7FFFFFFC},  // R1
        {32'hFFFFFFF9, 32'd2,        R, U, 32'd1},         // R1
        {32'h7FFFFFFF, 32'hFFFFFFFF, Q, S, 32'h80000001},  // R2
        {32'h80000000, 32'h7FFFFFFF, Q, S, 32'hFFFFFFFF},  // R2
        {32'h80000000, 32'h7FFFFFFF, R, S, 32'hFFFFFFFF},  // R2
        {32'hFFFFFFFF, 32'hA0000005, Q, S, 32'h00000000},  // R2
        {32'hFFFFFFFF, 32'hA0000005, R, S, 32'hFFFFFFFF},  // R2
        {32'hFFFFFFF9, 32'd2,        Q, S, 32'hFFFFFFFD},  // R2
        {32'hFFFFFFF9, 32'd2,        R, S, 32'hFFFFFFFF},  // R2
        {32'd7,        32'hFFFFFFFE, Q, S, 32'hFFFFFFFD},  // R2
        {32'd7,        32'hFFFFFFFE, R, S, 32'd1},         // R2
        {32'h80000000, 32'h80000000, Q, S, 32'd1},         // R2
        {32'h12345678, 32'd0,        Q, U, 32'hFFFFFFFF},  // R3
        {32'h12345678, 32'd0,        R, U, 32'h12345678},  // R3
        {32'hFFFFFFFB, 32'd0,        Q, S, 32'hFFFFFFFF},  // R3
        {32'hFFFFFFFB, 32'd0,        R, S, 32'hFFFFFFFB},  // R3
        {32'h80000000, 32'hFFFFFFFF, Q, S, 32'h80000000},  // R4
        {32'h80000000, 32'hFFFFFFFF, R, S, 32'h00000000},  // R4
        {32'h80000000, 32'hFFFFFFFF, R, U, 32'h80000000}   // R4 unsigned path
    };

    logic            clk;
    logic            rst_n;
    logic            start_i;
    logic [XLEN-1:0] dividend_i;
    logic [XLEN-1:0] divisor_i;
    logic [3:0]      op_i;
    logic [1:0]      sign_i;
    logic            busy_o;
    logic            done_o;
    logic [XLEN-1:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int_divider #(.XLEN(XLEN)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .op_i       (op_i),
        .sign_i     (sign_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Issue one operation and wait for completion; lat counts falling edges up to done.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                          input logic [1:0] sg, output logic [31:0] res, output int lat,
                          output bit saw_busy);
        @(negedge clk);
        dividend_i = a; divisor_i = b; op_i = op; sign_i = sg; start_i = 1'b1;
        saw_busy = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            if (busy_o) saw_busy = 1'b1;
            @(negedge clk);
            lat++;
        end
        res = result_o;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] res;
        int lat;
        bit saw_busy;
        int ndone;
        rst_n = 1'b0; start_i = 1'b0; dividend_i = '0; divisor_i = '0; op_i = Q; sign_i = U;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 busy", 32'(busy_o), 32'd0);
        check("R10 done", 32'(done_o), 32'd0);
        check("R10 result", result_o, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] a, b, exp;
            logic [3:0] op;
            logic [1:0] sg;
            bit sp;
            {a, b, op, sg, exp} = VEC[i];
            sp = (b == 32'd0) || (sg == S && a == 32'h80000000 && b == 32'hFFFFFFFF);
            run_op(a, b, op, sg, res, lat, saw_busy);
            check($sformatf("R1/R2/R3/R4 vec %0d result", i), res, exp);
            if (sp) begin
                check($sformatf("R5 vec %0d latency", i), 32'(lat), 32'd1);
                check($sformatf("R5 vec %0d busy seen", i), 32'(saw_busy), 32'd0);
            end else begin
                check($sformatf("R6 vec %0d latency", i), 32'(lat), 32'(XLEN + 1));
            end
            // R7 done lasts one cycle
            @(negedge clk);
            check($sformatf("R7 vec %0d done width", i), 32'(done_o), 32'd0);
        end

        // R8: a start during the loop is dropped
        @(negedge clk);
        dividend_i = 32'd1000; divisor_i = 32'd9; op_i = Q; sign_i = U; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        dividend_i = 32'd5; divisor_i = 32'd0; op_i = R; sign_i = S; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 6;
        while (!done_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R8 result of original operands", result_o, 32'd111);
        check("R8 original completion time", 32'(lat), 32'(XLEN + 1));
        res = result_o;
        ndone = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done_o) ndone++;
        end
        check("R8 no extra completion", 32'(ndone), 32'd0);
        // R9 result held while idle
        check("R9 result held", result_o, res);

        // R9 result held during a following loop until its done
        run_op(32'd50, 32'd5, Q, U, res, lat, saw_busy);
        check("R9 new result", res, 32'd10);
        @(negedge clk);
        dividend_i = 32'd77; divisor_i = 32'd3; op_i = R; sign_i = U; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 held while busy", result_o, 32'd10);
        while (!done_o) @(negedge clk);
        check("R1 remainder 77 mod 3", result_o, 32'd2);

        finished = 1;
        summary();
    end
endmodule